// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The block takes serial audio on a bit clock, a frame clock and several data lines, and turns it into parallel samples. It works as a clock slave: the bit clock, the frame clock and the data lines are all inputs. They are brought into the system clock domain through synchronizers. Data is sampled on each rising edge of the synchronized bit clock. One deserializer handles all of the following:

- stereo pairs carried on every data line, in these framings: I2S, left-justified, and right-justified at four word lengths;
- a time-division mode in which data line 0 alone carries 8 or 16 slots.

A frame begins on one edge of the frame clock, and a polarity input chooses which edge. The opposite edge is ignored, so a 50% frame clock and a narrow pulse give the same result. Every slot is 32 bit clocks wide. Each data line has its own output lane. A lane presents a 24-bit sign-extended sample, a channel number and a one-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high, and after it until the first sample is decoded, every valid strobe is low and every sample and channel output reads zero.
- R2: A frame starts at the bit clock where the sampled frame clock shows the chosen edge. `fs_rise_i`=1 selects a low-to-high change and 0 selects high-to-low. The opposite edge and the pulse width are ignored. Each slot is 32 bit clocks, and stereo frames hold two slots (left then right).
- R3: Format code 001 (left-justified) places the MSB on the frame-edge bit. The first 24 bits of each slot form the sample. Lane k reports channel 2k for the left slot and 2k+1 for the right slot.
- R4: Format code 000 (I2S) is as R3, except that the MSB arrives one bit clock after the frame-edge bit.
- R5: Format codes 011, 100, 101 and 110 are right-justified words of 24, 20, 18 and 16 bits. The LSB sits on bit 31 of the slot. The word is sign-extended to 24 bits, and earlier bits of the slot are ignored.
- R6: With `tdm_en_i`=1, only data line 0 is decoded. The frame holds 16 slots when `tdm_wide_i`=1 and 8 otherwise. The MSB sits on the frame-edge bit, and the first 24 bits of each slot are taken. The channel equals the slot number. Lanes 1 and up never strobe, and `fmt_i` has no effect.
- R7: In stereo mode, format codes 010 and 111 are reserved and produce no valid strobe on any lane.
- R8: After reset, no sample is produced before the first chosen frame-clock edge, whatever arrives on the data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fsync_i | input | 1 | Frame clock or frame pulse (asynchronous) |
| sd_i | input | NLINES | Serial data lines |
| fmt_i | input | 3 | Stereo format code |
| tdm_en_i | input | 1 | Select time-division mode on line 0 |
| tdm_wide_i | input | 1 | 16 slots per TDM frame when 1, 8 when 0 |
| fs_rise_i | input | 1 | Frame edge: 1 rising, 0 falling |
| smp_o | output | NLINES*SW | Sign-extended samples, lane k at bits k*SW |
| chan_o | output | NLINES*CHW | Channel number per lane |
| vld_o | output | NLINES | One-cycle strobe per lane |

## Verification
The bench builds the block with four data lines, 24-bit samples, 32-bit slots and a 16-slot wide TDM frame. This is the smallest configuration that still holds every stereo channel number and both TDM frame sizes. The bench sweeps all eight format codes, each under both frame-edge polarities, alternating between a clock-style and a pulse-style frame sync. The reserved codes, the I2S one-bit delay and each right-justified width, with its sign extension, are therefore all exercised. The TDM runs cover 8 and 16 slots with reserved and non-reserved format codes present, so the lanes that must stay silent are observed too.

// File: rtl/sairx_pkg.sv
package sairx_pkg;
  localparam logic [2:0] FMT_I2S  = 3'b000;
  localparam logic [2:0] FMT_LJ   = 3'b001;
  localparam logic [2:0] FMT_RJ24 = 3'b011;
  localparam logic [2:0] FMT_RJ20 = 3'b100;
  localparam logic [2:0] FMT_RJ18 = 3'b101;
  localparam logic [2:0] FMT_RJ16 = 3'b110;

  function automatic logic fmt_is_rj(input logic [2:0] f);
    return (f == FMT_RJ24) || (f == FMT_RJ20) || (f == FMT_RJ18) || (f == FMT_RJ16);
  endfunction

  function automatic logic fmt_known(input logic [2:0] f);
    return (f == FMT_I2S) || (f == FMT_LJ) || fmt_is_rj(f);
  endfunction
endpackage

// File: rtl/sairx_sync.sv
module sairx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sairx_framer.sv
module sairx_framer #(
  parameter int SLOT_BITS  = 32,
  parameter int WIDE_SLOTS = 16,
  parameter int POSW       = 9
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            bit_stb_i,
  input  logic            fs_i,
  input  logic            fs_rise_i,
  input  logic            tdm_en_i,
  input  logic            tdm_wide_i,
  input  logic            i2s_dly_i,
  output logic [POSW-1:0] pos_o,
  output logic            pos_vld_o
);
  localparam logic [POSW-1:0] LAST_WIDE   = POSW'(WIDE_SLOTS * SLOT_BITS - 1);
  localparam logic [POSW-1:0] LAST_NARROW = POSW'((WIDE_SLOTS / 2) * SLOT_BITS - 1);
  localparam logic [POSW-1:0] LAST_PAIR   = POSW'(2 * SLOT_BITS - 1);

  logic            fs_prev_q, primed_q, locked_q;
  logic [POSW-1:0] pos_q;
  logic [POSW-1:0] last_pos, start_pos, next_pos;
  logic            frame_edge;

  always_comb begin
    if (tdm_en_i) last_pos = tdm_wide_i ? LAST_WIDE : LAST_NARROW;
    else          last_pos = LAST_PAIR;
    start_pos  = i2s_dly_i ? last_pos : '0;
    next_pos   = (pos_q >= last_pos) ? '0 : pos_q + 1'b1;
    frame_edge = bit_stb_i & primed_q &
                 (fs_rise_i ? (fs_i & ~fs_prev_q) : (~fs_i & fs_prev_q));
    pos_o      = frame_edge ? start_pos : next_pos;
    pos_vld_o  = bit_stb_i & (frame_edge | locked_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fs_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      locked_q  <= 1'b0;
      pos_q     <= '0;
    end else if (bit_stb_i) begin
      fs_prev_q <= fs_i;
      primed_q  <= 1'b1;
      if (frame_edge | locked_q) pos_q <= pos_o;
      if (frame_edge) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sairx_lane.sv
module sairx_lane
  import sairx_pkg::*;
#(
  parameter int SW        = 24,
  parameter int SLOT_BITS = 32,
  parameter int POSW      = 9,
  parameter int CHW       = 4,
  parameter int LANE      = 0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            bit_stb_i,
  input  logic            sd_i,
  input  logic [POSW-1:0] pos_i,
  input  logic            pos_vld_i,
  input  logic            tdm_en_i,
  input  logic [2:0]      fmt_i,
  output logic [SW-1:0]   smp_o,
  output logic [CHW-1:0]  chan_o,
  output logic            vld_o
);
  localparam int SLOT_LG = $clog2(SLOT_BITS);
  localparam int SELW    = POSW - SLOT_LG;
  localparam int PW      = $clog2(SW + 1);
  localparam logic [PW-1:0] PAD24 = PW'(SW - 24);
  localparam logic [PW-1:0] PAD20 = PW'(SW - 20);
  localparam logic [PW-1:0] PAD18 = PW'(SW - 18);
  localparam logic [PW-1:0] PAD16 = PW'(SW - 16);
  localparam logic [CHW-1:0] PAIR_BASE = CHW'(2 * LANE);

  logic [SLOT_BITS-1:0] sh_q, sh_nx;
  logic [SELW-1:0]      slot;
  logic [SLOT_LG-1:0]   bit_in_slot, emit_at;
  logic                 rj, lane_on, fire;
  logic [PW-1:0]        pad;
  logic [SW-1:0]        raw, word;
  logic signed [SW-1:0] up, ext;
  logic [CHW-1:0]       chan_nx;

  always_comb begin
    sh_nx       = {sh_q[SLOT_BITS-2:0], sd_i};
    slot        = pos_i[POSW-1:SLOT_LG];
    bit_in_slot = pos_i[SLOT_LG-1:0];
    rj          = ~tdm_en_i & fmt_is_rj(fmt_i);
    emit_at     = rj ? SLOT_LG'(SLOT_BITS - 1) : SLOT_LG'(SW - 1);
    lane_on     = tdm_en_i ? (LANE == 0) : fmt_known(fmt_i);
    fire        = pos_vld_i & lane_on & (bit_in_slot == emit_at);
    case (fmt_i)
      FMT_RJ24: pad = PAD24;
      FMT_RJ20: pad = PAD20;
      FMT_RJ18: pad = PAD18;
      FMT_RJ16: pad = PAD16;
      default:  pad = '0;
    endcase
    raw     = sh_nx[SW-1:0];
    up      = $signed(raw << pad);
    ext     = up >>> pad;
    word    = rj ? ext : raw;
    chan_nx = tdm_en_i ? CHW'(slot) : (PAIR_BASE | CHW'(slot[0]));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '0;
      smp_o  <= '0;
      chan_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= fire;
      if (bit_stb_i) sh_q <= sh_nx;
      if (fire) begin
        smp_o  <= word;
        chan_o <= chan_nx;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sairx_pkg::*;
#(
  parameter int NLINES      = 4,
  parameter int SW          = 24,
  parameter int SLOT_BITS   = 32,
  parameter int WIDE_SLOTS  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = $clog2(WIDE_SLOTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  bclk_i,
  input  logic                  fsync_i,
  input  logic [NLINES-1:0]     sd_i,
  input  logic [2:0]            fmt_i,
  input  logic                  tdm_en_i,
  input  logic                  tdm_wide_i,
  input  logic                  fs_rise_i,
  output logic [NLINES*SW-1:0]  smp_o,
  output logic [NLINES*CHW-1:0] chan_o,
  output logic [NLINES-1:0]     vld_o
);
  localparam int POSW = $clog2(WIDE_SLOTS * SLOT_BITS);

  logic [NLINES+1:0] raw_in, synced;
  logic              bclk_s, fs_s, bclk_d, bit_stb;
  logic [NLINES-1:0] sd_s;
  logic [POSW-1:0]   pos;
  logic              pos_vld, i2s_dly;

  assign raw_in  = {sd_i, fsync_i, bclk_i};
  assign bclk_s  = synced[0];
  assign fs_s    = synced[1];
  assign sd_s    = synced[NLINES+1:2];
  assign i2s_dly = ~tdm_en_i & (fmt_i == FMT_I2S);
  assign bit_stb = bclk_s & ~bclk_d;

  sairx_sync #(.W(NLINES + 2), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) bclk_d <= 1'b1;
    else       bclk_d <= bclk_s;
  end

  sairx_framer #(.SLOT_BITS(SLOT_BITS), .WIDE_SLOTS(WIDE_SLOTS), .POSW(POSW)) framer_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bit_stb_i  (bit_stb),
    .fs_i       (fs_s),
    .fs_rise_i  (fs_rise_i),
    .tdm_en_i   (tdm_en_i),
    .tdm_wide_i (tdm_wide_i),
    .i2s_dly_i  (i2s_dly),
    .pos_o      (pos),
    .pos_vld_o  (pos_vld)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_lane
    sairx_lane #(
      .SW(SW), .SLOT_BITS(SLOT_BITS), .POSW(POSW), .CHW(CHW), .LANE(g)
    ) lane_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .bit_stb_i (bit_stb),
      .sd_i      (sd_s[g]),
      .pos_i     (pos),
      .pos_vld_i (pos_vld),
      .tdm_en_i  (tdm_en_i),
      .fmt_i     (fmt_i),
      .smp_o     (smp_o[g*SW +: SW]),
      .chan_o    (chan_o[g*CHW +: CHW]),
      .vld_o     (vld_o[g])
    );
  end
endmodule

// File: rtl/sairx_chk.sv
module sairx_chk #(
  parameter int NLINES     = 4,
  parameter int SW         = 24,
  parameter int CHW        = 4,
  parameter int WIDE_SLOTS = 16
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  bit_stb,
  input logic                  tdm_en_i,
  input logic                  tdm_wide_i,
  input logic [2:0]            fmt_i,
  input logic [NLINES-1:0]     vld_o,
  input logic [NLINES*CHW-1:0] chan_o,
  input logic [NLINES*SW-1:0]  smp_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i) rst_i |=> (vld_o == '0));

  p_strobe_follows_bit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_o != '0) |-> $past(bit_stb));

  p_reserved_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(tdm_en_i) && ($past(fmt_i) == 3'b010 || $past(fmt_i) == 3'b111)) |-> (vld_o == '0));

  p_tdm8_chan_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_o[0] && $past(tdm_en_i) && !$past(tdm_wide_i)) |-> (chan_o[CHW-1:0] < CHW'(WIDE_SLOTS / 2)));

  for (genvar i = 0; i < NLINES; i++) begin : g_lane_chk
    if (i > 0) begin : g_upper
      p_tdm_lane0_only_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o[i] |-> !$past(tdm_en_i));
    end

    p_stereo_chan_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_o[i] && !$past(tdm_en_i)) |-> (chan_o[i*CHW+1 +: CHW-1] == (CHW-1)'(i)));

    p_rj16_signext_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_o[i] && !$past(tdm_en_i) && $past(fmt_i) == 3'b110) |->
      (smp_o[i*SW+15 +: SW-15] == '0 || smp_o[i*SW+15 +: SW-15] == '1));
  end
endmodule

bind serial_audio_rx sairx_chk #(
  .NLINES(NLINES), .SW(SW), .CHW(CHW), .WIDE_SLOTS(WIDE_SLOTS)
) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .bit_stb    (bit_stb),
  .tdm_en_i   (tdm_en_i),
  .tdm_wide_i (tdm_wide_i),
  .fmt_i      (fmt_i),
  .vld_o      (vld_o),
  .chan_o     (chan_o),
  .smp_o      (smp_o)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  localparam int NL = 4, SW = 24, SLOT = 32, WIDE = 16, CHW = 4, H = 3;

  logic clk = 1'b0, rst = 1'b1, bclk = 1'b0, fsync = 1'b0;
  logic [NL-1:0] sd = '0;
  logic [2:0] fmt = 3'b000;
  logic tdm = 1'b0, wide = 1'b0, pol = 1'b0;
  wire [NL*SW-1:0]  smp;
  wire [NL*CHW-1:0] chan;
  wire [NL-1:0]     vld;

  always #2 clk = ~clk;

  serial_audio_rx #(.NLINES(NL), .SW(SW), .SLOT_BITS(SLOT), .WIDE_SLOTS(WIDE), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_i(rst), .bclk_i(bclk), .fsync_i(fsync), .sd_i(sd), .fmt_i(fmt),
    .tdm_en_i(tdm), .tdm_wide_i(wide), .fs_rise_i(pol),
    .smp_o(smp), .chan_o(chan), .vld_o(vld)
  );

  int checks = 0, errors = 0;
  logic [SW-1:0]  exp_v [NL][64];
  logic [CHW-1:0] exp_c [NL][64];
  int exp_n [NL];
  int got_n [NL];
  string tag = "R1";
  bit done = 1'b0;

  task automatic chk(input bit ok, input string t, input string what, input longint a, input longint e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, a, e);
    end
  endtask

  function automatic logic [SW-1:0] sval(input int seed, input int s, input int l);
    logic [31:0] x;
    x = 32'(seed) * 32'd1103515245 + 32'(s) * 32'd86413 + 32'(l) * 32'd99991 + 32'd17;
    x = x ^ (x >> 13);
    x = x * 32'd2654435761;
    return x[31:8];
  endfunction

  function automatic int rjw(input logic [2:0] f);
    case (f)
      3'b011: return 24;
      3'b100: return 20;
      3'b101: return 18;
      3'b110: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic data_bit(input logic [2:0] f, input bit t, input int seed, input int dpos, input int l);
    int slot = dpos / SLOT;
    int q = dpos % SLOT;
    int w = t ? 0 : rjw(f);
    logic [SW-1:0] v = sval(seed, slot, l);
    if (w > 0) return (q >= SLOT - w) ? v[SLOT-1-q] : ((q + l) % 3 == 0);
    return (q < SW) ? v[SW-1-q] : ((q + l) % 2 == 1);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < NL; l++) begin
        if (vld[l]) begin
          if (got_n[l] < exp_n[l]) begin
            chk(smp[l*SW +: SW] == exp_v[l][got_n[l]], tag, $sformatf("lane %0d sample %0d value", l, got_n[l]),
                smp[l*SW +: SW], exp_v[l][got_n[l]]);
            chk(chan[l*CHW +: CHW] == exp_c[l][got_n[l]], tag, $sformatf("lane %0d sample %0d channel", l, got_n[l]),
                chan[l*CHW +: CHW], exp_c[l][got_n[l]]);
          end else begin
            chk(1'b0, tag, $sformatf("lane %0d unexpected strobe", l), got_n[l] + 1, exp_n[l]);
          end
          got_n[l]++;
        end
      end
    end
  end

  task automatic send_bit(input logic fs_v, input logic [NL-1:0] sd_v);
    bclk = 1'b0;
    fsync = fs_v;
    sd = sd_v;
    repeat (H) @(negedge clk);
    bclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] f, input bit t, input bit wd, input bit p, input bit pulse,
                     input int seed, input int nfr);
    int slots = t ? (wd ? 16 : 8) : 2;
    int flen = slots * SLOT;
    bit d = !t && (f == 3'b000);
    bit known = t || (f == 3'b000) || (f == 3'b001) || (rjw(f) > 0);
    int w = t ? 0 : rjw(f);
    int tot;
    string tg;
    if (t) tg = "R6";
    else if (f == 3'b000) tg = "R4";
    else if (f == 3'b001) tg = "R3";
    else if (w > 0) tg = "R5";
    else tg = "R7";
    @(negedge clk);
    rst = 1'b1; bclk = 1'b0; fmt = f; tdm = t; wide = wd; pol = p; fsync = !p; sd = '0;
    tag = {tg, " R2"};
    for (int l = 0; l < NL; l++) begin
      exp_n[l] = 0;
      got_n[l] = 0;
    end
    if (known) begin
      for (int fr = 0; fr < nfr; fr++) begin
        for (int s = 0; s < slots; s++) begin
          for (int l = 0; l < (t ? 1 : NL); l++) begin
            logic [SW-1:0] v = sval(seed, s, l);
            if (w > 0) begin
              int lo = int'(v) & ((1 << w) - 1);
              if (lo >= (1 << (w - 1))) lo = lo - (1 << w);
              exp_v[l][exp_n[l]] = SW'(lo);
            end else begin
              exp_v[l][exp_n[l]] = v;
            end
            exp_c[l][exp_n[l]] = t ? CHW'(s) : CHW'(2 * l + s);
            exp_n[l]++;
          end
        end
      end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 40; k++) send_bit(!p, NL'(k * 5 + seed));
    repeat (10) @(negedge clk);
    tot = got_n[0] + got_n[1] + got_n[2] + got_n[3];
    chk(tot == 0, "R8", "strobes before first frame edge", tot, 0);
    for (int fr = 0; fr < nfr; fr++) begin
      for (int pp = 0; pp < flen; pp++) begin
        logic fs_v;
        logic [NL-1:0] sd_v;
        int dpos = d ? ((pp == 0) ? flen - 1 : pp - 1) : pp;
        if (pulse) fs_v = (pp == 0) ? p : !p;
        else       fs_v = (pp < flen / 2) ? p : !p;
        for (int l = 0; l < NL; l++) sd_v[l] = data_bit(f, t, seed, dpos, l);
        send_bit(fs_v, sd_v);
      end
    end
    send_bit(!p, '0);
    send_bit(!p, '0);
    repeat (20) @(negedge clk);
    for (int l = 0; l < NL; l++)
      chk(got_n[l] == exp_n[l], tag, $sformatf("strobe count lane %0d", l), got_n[l], exp_n[l]);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      exp_n[l] = 0;
      got_n[l] = 0;
    end
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(vld == '0, "R1", "strobes in reset", vld, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(vld == '0, "R1", "strobes after reset", vld, 0);
    chk(smp == '0, "R1", "samples after reset", smp, 0);
    chk(chan == '0, "R1", "channels after reset", chan, 0);

    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 2; p++)
        run(3'(f), 1'b0, 1'b0, p[0], f[0] ^ p[0], f * 2 + p + 1, 3);

    run(3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 21, 2);
    run(3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 22, 2);
    run(3'b011, 1'b1, 1'b1, 1'b0, 1'b1, 23, 2);
    run(3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 24, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s: actual running expected finished", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule